// File: doc/BRIEF.md
# DMA Channel Address Generator with Circular Windows

This block keeps the source and destination addresses of one DMA channel and moves them forward as data beats complete. The read side of the engine pulses a strobe when a source beat finishes, and the write side pulses its own strobe when a destination beat finishes. On each strobe the matching address grows by the access width of that side, 1, 2 or 4 bytes. It does so only when stepping is enabled for that side, or when that side is the one that auto-alignment picks.

Either address can be held inside a power-of-two circular window. In that case only the low address bits step, and the bits above the window never change. When the channel is activated, the block checks both access-size codes and raises a configuration-error flag if either code is the reserved one. Bus cycles, arbitration and byte counting are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both addresses and `cfg_err` become 0 at that edge.
- R2: A load strobe (`src_ld` / `dst_ld`) puts its data into the address on the next edge. It wins over a beat strobe in the same cycle.
- R3: Size codes on `src_size` / `dst_size` are 2'b00 = 4 bytes, 2'b01 = 1 byte, 2'b10 = 2 bytes and 2'b11 = reserved. A stepping address grows by that byte count, and a reserved code gives a step of 0.
- R4: The source address changes only on `rd_beat` and the destination address only on `wr_beat`. With no load and no strobe on a side, its address holds. Each update is visible one edge after the strobe.
- R5: When a side's step enable (`src_inc` / `dst_inc`) is 0 and that side is not the auto-aligned side, its beat strobe leaves the address unchanged.
- R6: Window code 4'b0000 means linear stepping, with modulo 2^32 wrap. A code n from 1 to 15 selects a window of 2^(n+3) bytes, 16 B up to 256 KB. The address bits below n+3 step and wrap, and the bits from n+3 upward stay fixed.
- R7: When `auto_align` is 1, the source is the aligned side if its byte count is at least the destination's; otherwise the destination is. The aligned side steps on its strobe even when its step enable is 0. The byte count of a reserved code is 0.
- R8: On an `activate` edge, `cfg_err` becomes 1 if either size code is 2'b11 and 0 otherwise. Without `activate`, `cfg_err` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ld | input | 1 | Load source address |
| src_ld_val | input | 32 | Source address load value |
| dst_ld | input | 1 | Load destination address |
| dst_ld_val | input | 32 | Destination address load value |
| src_size | input | 2 | Source access size code |
| dst_size | input | 2 | Destination access size code |
| src_inc | input | 1 | Source step enable |
| dst_inc | input | 1 | Destination step enable |
| src_win | input | 4 | Source circular window code |
| dst_win | input | 4 | Destination circular window code |
| auto_align | input | 1 | Auto-alignment enable |
| activate | input | 1 | Channel activation strobe |
| rd_beat | input | 1 | Source beat completed |
| wr_beat | input | 1 | Destination beat completed |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| cfg_err | output | 1 | Configuration error flag |

## Verification
A wrong step, a missed strobe or a wrong window mask shows on `src_addr` or `dst_addr` one edge after the beat that caused it. Because every later address builds on that value, the error stays in place until the next load. Escaped upper bits show up as a jump outside the window. An auto-align choice on the wrong side shows up as a side that moves when it should stay, or the reverse. A bad size check shows on `cfg_err` one edge after `activate`, and the flag then holds that wrong value until the next activation.

// File: rtl/dma_ag_pkg.sv
// Shared types and helpers for the DMA channel address generator.
// Assumes byte addressing; access widths are 1, 2 or 4 bytes.
package dma_ag_pkg;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Lowest window code maps to 2^(code + WIN_BASE) bytes.
    localparam int WIN_BASE = 3;

    // Byte count of one access; the reserved code yields 0.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (acc_size_e'(code))
            SZ_WORD: size_bytes = 3'd4;
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_ag_size_dec.sv
// Decodes both access-size codes into byte steps and picks the side that
// auto-alignment forces to step. Purely combinational.
module dma_ag_size_dec
    import dma_ag_pkg::*;
(
    input  logic [1:0] src_size,
    input  logic [1:0] dst_size,
    input  logic       auto_align,
    output logic [2:0] src_step,
    output logic [2:0] dst_step,
    output logic       src_force,
    output logic       dst_force
);

    // Byte step per side and the aligned-side choice (source wins ties).
    always_comb begin
        src_step  = size_bytes(src_size);
        dst_step  = size_bytes(dst_size);
        src_force = auto_align && (src_step >= dst_step);
        dst_force = auto_align && (src_step <  dst_step);
    end

endmodule

// File: rtl/dma_ag_addr_chan.sv
// One address register: loads on request, otherwise steps on its beat strobe
// when enabled, wrapping inside a power-of-two window when one is selected.
// Assumes the window code is stable in the cycle of the beat.
module dma_ag_addr_chan
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              beat,
    input  logic              step_en,
    input  logic [2:0]        step,
    input  logic [WIN_W-1:0]  win,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] next_addr;

    // Mask of the bits that may change: all bits when linear.
    always_comb begin
        if (win == '0) begin
            low_mask = '1;
        end else begin
            low_mask = (ONE << (int'(win) + WIN_BASE)) - ONE;
        end
    end

    // Stepped address with bits above the window taken from the old value.
    always_comb begin
        sum       = addr + ADDR_W'(step);
        next_addr = (addr & ~low_mask) | (sum & low_mask);
    end

    // Address register: reset, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_val;
        end else if (beat && step_en) begin
            addr <= next_addr;
        end
    end

endmodule

// File: rtl/dma_ag_cfg_chk.sv
// Evaluates the size codes on channel activation and holds the verdict
// until the next activation.
module dma_ag_cfg_chk
    import dma_ag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       activate,
    input  logic [1:0] src_size,
    input  logic [1:0] dst_size,
    output logic       cfg_err
);

    // Error flag register: refreshed only by activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (activate) begin
            cfg_err <= (acc_size_e'(src_size) == SZ_RSVD) ||
                       (acc_size_e'(dst_size) == SZ_RSVD);
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
// Top of the DMA channel address generator. Side 0 is the source (read
// beats), side 1 the destination (write beats). Assumes strobes are
// single-cycle pulses synchronous to clk.
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_ld,
    input  logic [ADDR_W-1:0] src_ld_val,
    input  logic              dst_ld,
    input  logic [ADDR_W-1:0] dst_ld_val,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic [WIN_W-1:0]  src_win,
    input  logic [WIN_W-1:0]  dst_win,
    input  logic              auto_align,
    input  logic              activate,
    input  logic              rd_beat,
    input  logic              wr_beat,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              cfg_err
);

    localparam int SIDES = 2;

    logic [2:0] src_step, dst_step;
    logic       src_force, dst_force;

    logic [SIDES-1:0]             side_ld, side_beat, side_en;
    logic [SIDES-1:0][ADDR_W-1:0] side_val, side_addr;
    logic [SIDES-1:0][2:0]        side_step;
    logic [SIDES-1:0][WIN_W-1:0]  side_win;

    dma_ag_size_dec u_dec (
        .src_size  (src_size),
        .dst_size  (dst_size),
        .auto_align(auto_align),
        .src_step  (src_step),
        .dst_step  (dst_step),
        .src_force (src_force),
        .dst_force (dst_force)
    );

    // Gather per-side controls into arrays indexed by side.
    always_comb begin
        side_ld   = {dst_ld, src_ld};
        side_val  = {dst_ld_val, src_ld_val};
        side_beat = {wr_beat, rd_beat};
        side_en   = {dst_inc | dst_force, src_inc | src_force};
        side_step = {dst_step, src_step};
        side_win  = {dst_win, src_win};
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_ag_addr_chan #(
            .ADDR_W(ADDR_W),
            .WIN_W (WIN_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (side_ld[g]),
            .ld_val (side_val[g]),
            .beat   (side_beat[g]),
            .step_en(side_en[g]),
            .step   (side_step[g]),
            .win    (side_win[g]),
            .addr   (side_addr[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];

    dma_ag_cfg_chk u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .activate(activate),
        .src_size(src_size),
        .dst_size(dst_size),
        .cfg_err (cfg_err)
    );

endmodule

// File: rtl/dma_addr_gen_sva.sv
// Port-level checker for dma_addr_gen, attached with bind below.
module dma_addr_gen_sva #(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_ld,
    input logic [ADDR_W-1:0] src_ld_val,
    input logic              dst_ld,
    input logic [ADDR_W-1:0] dst_ld_val,
    input logic              src_inc,
    input logic [WIN_W-1:0]  src_win,
    input logic [1:0]        src_size,
    input logic [1:0]        dst_size,
    input logic              auto_align,
    input logic              activate,
    input logic              rd_beat,
    input logic              wr_beat,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              cfg_err
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Bits above the source window that must never move on a step.
    logic [ADDR_W-1:0] src_keep;
    always_comb src_keep = ~((ONE << (int'(src_win) + 3)) - ONE);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (src_addr == '0 && dst_addr == '0 && !cfg_err));

    assert_src_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_ld |=> src_addr == $past(src_ld_val));

    assert_dst_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dst_ld |=> dst_addr == $past(dst_ld_val));

    assert_src_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ld && !rd_beat) |=> $stable(src_addr));

    assert_dst_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dst_ld && !wr_beat) |=> $stable(dst_addr));

    assert_src_noinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ld && rd_beat && !src_inc && !auto_align) |=> $stable(src_addr));

    assert_src_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ld && rd_beat && src_win != '0)
        |=> ((src_addr ^ $past(src_addr)) & $past(src_keep)) == '0);

    assert_err_on_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
        activate |=> cfg_err == ($past(src_size) == 2'b11 || $past(dst_size) == 2'b11));

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !activate |=> $stable(cfg_err));

endmodule

bind dma_addr_gen dma_addr_gen_sva #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_ld    (src_ld),
    .src_ld_val(src_ld_val),
    .dst_ld    (dst_ld),
    .dst_ld_val(dst_ld_val),
    .src_inc   (src_inc),
    .src_win   (src_win),
    .src_size  (src_size),
    .dst_size  (dst_size),
    .auto_align(auto_align),
    .activate  (activate),
    .rd_beat   (rd_beat),
    .wr_beat   (wr_beat),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .cfg_err   (cfg_err)
);

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_ld = 0, dst_ld = 0;
    logic [31:0] src_ld_val = 0, dst_ld_val = 0;
    logic [1:0]  src_size = 0, dst_size = 0;
    logic        src_inc = 0, dst_inc = 0;
    logic [3:0]  src_win = 0, dst_win = 0;
    logic        auto_align = 0, activate = 0, rd_beat = 0, wr_beat = 0;
    logic [31:0] src_addr, dst_addr;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;
    logic [31:0] e_src = 0, e_dst = 0;
    logic        e_err = 0;

    always #10 clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_ld(src_ld), .src_ld_val(src_ld_val),
        .dst_ld(dst_ld), .dst_ld_val(dst_ld_val),
        .src_size(src_size), .dst_size(dst_size),
        .src_inc(src_inc), .dst_inc(dst_inc),
        .src_win(src_win), .dst_win(dst_win),
        .auto_align(auto_align), .activate(activate),
        .rd_beat(rd_beat), .wr_beat(wr_beat),
        .src_addr(src_addr), .dst_addr(dst_addr), .cfg_err(cfg_err)
    );

    // Byte count of a size code per R3.
    function automatic int m_bytes(input logic [1:0] c);
        return (c == 2'b00) ? 4 : (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
    endfunction

    // Stepped address per R6.
    function automatic logic [31:0] m_next(input logic [31:0] a, input int st,
                                           input logic [3:0] w);
        logic [31:0] m;
        m = (w == 0) ? 32'hFFFF_FFFF : ((32'd1 << (w + 3)) - 32'd1);
        return (a & ~m) | ((a + 32'(st)) & m);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One clock: update the model from the driven inputs, compare at negedge.
    task automatic cyc(input string tag);
        logic sf, df;
        @(posedge clk);
        sf = auto_align && (m_bytes(src_size) >= m_bytes(dst_size));
        df = auto_align && (m_bytes(src_size) <  m_bytes(dst_size));
        if (!rst_n) begin
            e_src = 0; e_dst = 0; e_err = 0;
        end else begin
            if (src_ld) e_src = src_ld_val;
            else if (rd_beat && (src_inc || sf)) e_src = m_next(e_src, m_bytes(src_size), src_win);
            if (dst_ld) e_dst = dst_ld_val;
            else if (wr_beat && (dst_inc || df)) e_dst = m_next(e_dst, m_bytes(dst_size), dst_win);
            if (activate) e_err = (src_size == 2'b11) || (dst_size == 2'b11);
        end
        @(negedge clk);
        chk({tag, " src"}, src_addr, e_src);
        chk({tag, " dst"}, dst_addr, e_dst);
        chk({tag, " err"}, {31'd0, cfg_err}, {31'd0, e_err});
    endtask

    task automatic idle();
        src_ld = 0; dst_ld = 0; rd_beat = 0; wr_beat = 0; activate = 0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d);
        idle(); src_ld = 1; dst_ld = 1; src_ld_val = s; dst_ld_val = d;
        cyc("R2 load"); idle();
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        @(negedge clk);
        cyc("R1 reset");
        cyc("R1 reset");
        chk("R1 src literal", src_addr, 32'h0);
        rst_n = 1;

        // R2: load wins over simultaneous beats
        src_inc = 1; dst_inc = 1;
        src_ld = 1; dst_ld = 1; src_ld_val = 32'h100; dst_ld_val = 32'h200;
        rd_beat = 1; wr_beat = 1;
        cyc("R2 load priority");
        chk("R2 literal", src_addr, 32'h100);
        idle();

        // R3: every size code, both sides stepping
        for (int c = 0; c < 4; c++) begin
            src_size = 2'(c); dst_size = 2'(3 - c);
            rd_beat = 1; wr_beat = 1;
            cyc("R3 size step");
        end
        idle();
        src_size = 2'b01; rd_beat = 1; cyc("R3 byte step");
        src_size = 2'b00; cyc("R3 word step");
        idle();

        // R4: one strobe at a time, and no strobe
        rd_beat = 1; cyc("R4 read only");
        idle(); wr_beat = 1; cyc("R4 write only");
        idle(); cyc("R4 none");

        // R5: step disabled
        src_inc = 0; dst_inc = 0; rd_beat = 1; wr_beat = 1;
        cyc("R5 no inc"); cyc("R5 no inc");
        idle(); src_inc = 1; dst_inc = 1;

        // R6: window wrap at the smallest and largest windows, and linear wrap
        src_size = 2'b00; dst_size = 2'b10;
        load(32'h1000_000C, 32'hFFFF_FFFE);
        src_win = 4'd1; dst_win = 4'd0; rd_beat = 1; wr_beat = 1;
        cyc("R6 16B wrap / linear wrap");
        chk("R6 16B literal", src_addr, 32'h1000_0000);
        chk("R6 linear literal", dst_addr, 32'h0000_0000);
        idle();
        load(32'hAB03_FFFC, 32'h5555_7FFE);
        src_win = 4'd15; dst_win = 4'd12; rd_beat = 1; wr_beat = 1;
        cyc("R6 256KB wrap");
        chk("R6 256KB literal", src_addr, 32'hAB00_0000);
        idle(); src_win = 0; dst_win = 0;

        // R7: auto-align picks a side that steps despite a cleared enable
        src_inc = 0; dst_inc = 0; auto_align = 1;
        src_size = 2'b00; dst_size = 2'b01; rd_beat = 1; wr_beat = 1;
        cyc("R7 src aligned");
        src_size = 2'b01; dst_size = 2'b10;
        cyc("R7 dst aligned");
        src_size = 2'b10; dst_size = 2'b10;
        cyc("R7 tie to src");
        src_size = 2'b11; dst_size = 2'b01;
        cyc("R7 reserved src");
        idle(); auto_align = 0; src_inc = 1; dst_inc = 1;

        // R8: activation verdicts and hold
        src_size = 2'b11; dst_size = 2'b00; activate = 1; cyc("R8 bad src");
        activate = 0; src_size = 2'b00; cyc("R8 hold");
        dst_size = 2'b11; activate = 1; cyc("R8 bad dst");
        dst_size = 2'b01; cyc("R8 legal clears");
        activate = 0; dst_size = 2'b11; cyc("R8 hold clear");

        // Random mix covering R2..R8
        for (int i = 0; i < 3000; i++) begin
            src_ld     = ($urandom % 16) == 0;
            dst_ld     = ($urandom % 16) == 0;
            src_ld_val = $urandom;
            dst_ld_val = $urandom;
            src_size   = 2'($urandom);
            dst_size   = 2'($urandom);
            src_inc    = 1'($urandom);
            dst_inc    = 1'($urandom);
            src_win    = 4'($urandom);
            dst_win    = 4'($urandom);
            auto_align = 1'($urandom);
            activate   = ($urandom % 8) == 0;
            rd_beat    = 1'($urandom);
            wr_beat    = 1'($urandom);
            cyc("R4 R6 R7 random");
        end
        idle();

        // R1: reset in mid-operation
        rst_n = 0; cyc("R1 reset again");
        rst_n = 1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule